// File: doc/BRIEF.md
# Data-Side Translation Buffer with Access Checking

This block turns load and store effective addresses into real addresses for a data cache. It holds recently used 4 kB page translations in a two-way, 64-set array. Each request carries an effective address, a store flag and the problem-state flag. Each accepted request receives one response, exactly one cycle later. The response is either a hit, with the real address and a cache-inhibited attribute, or one or more error flags. A miss is reported apart from a permission fault and from a reference/change fault, so that the consumer can report the right status. When the data-relocate input is low, the block does no translation: it passes the address through and marks the 0xC??????? window as cache-inhibited.

A page walker installs translations through a fill port. A fill goes to the way named by a per-set toggle, unless that page is already present in the set, in which case it is replaced in place. An invalidate port takes the operand of a TLB-invalidate operation. That operand either flushes the whole array or drops the single page that it names.

The request side is valid/ready. A request is taken on a rising edge when `req_valid` and `req_ready` are both high. `req_ready` falls for exactly the one cycle in which a response carrying any error flag is presented, so a request offered in that cycle is cancelled and receives no response. The response side has no back-pressure: `rsp_valid` is high for one cycle and the consumer must take the response then. Fill and invalidate are plain single-cycle strobes.

Top module: `dtlb_core`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0. Every accepted request gives `rsp_valid` high in the next cycle, with exactly one of two outcomes: `rsp_hit`, or at least one of the error flags.
- R2: With `relocate` low, the response is a hit whose `rsp_ra` equals the low `RA_W` bits of the effective address.
- R3: With `relocate` low, `rsp_inhibit` is 1 exactly when effective address bits 31:28 equal 4'hC.
- R4: With `relocate` high, if no valid entry of set EA[17:12] holds page EA[63:12], the response has `rsp_miss` = 1 and no other flag.
- R5: On a translated hit, `rsp_ra` = {stored real page number, EA[11:0]} and `rsp_inhibit` equals fill attribute bit 5 (cache-inhibited).
- R6: A permission fault (`rsp_perm_err`) is raised when attribute bit 0 (privileged-only) is 1 and problem state is 1. It is also raised on a store with attribute bit 2 (write allowed) at 0, and on a load with both bit 1 (read allowed) and bit 2 at 0.
- R7: A reference/change fault (`rsp_rc_err`) is raised when attribute bit 3 (referenced) is 0, or on a store when bit 4 (changed) is 0. The two fault kinds are reported independently, and a hit is reported only when neither is present.
- R8: In the cycle after a response with any error flag, `req_ready` is 0, and a request offered then receives no response.
- R9: A fill of a page that is not present in its set writes the set's victim way, and that set's victim toggles. Each set's victim is independent of other sets, so the third distinct page filled into a set evicts the first one.
- R10: A fill of a page already present in its set overwrites that entry and leaves the victim unchanged.
- R11: An invalidate with operand bit 10 or bit 11 set removes every entry.
- R12: An invalidate with operand bits 10 and 11 both clear removes only an entry holding page operand[63:12]. Other pages in the same set remain.
- R13: A fill in the same cycle as an invalidate is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| relocate | input | 1 | Data-relocate enable for the request |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_ea | input | EA_W | Effective address |
| req_store | input | 1 | 1 = store, 0 = load |
| req_problem | input | 1 | Problem (user) state |
| rsp_valid | output | 1 | Response present |
| rsp_ra | output | RA_W | Real address |
| rsp_inhibit | output | 1 | Access is cache-inhibited |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No translation present |
| rsp_perm_err | output | 1 | Permission fault |
| rsp_rc_err | output | 1 | Reference/change fault |
| fill_valid | input | 1 | Install a translation |
| fill_page | input | EA_W-12 | Effective page number to install |
| fill_rpn | input | RA_W-12 | Real page number |
| fill_attr | input | 6 | {inhibit, changed, referenced, write ok, read ok, privileged-only} |
| inv_valid | input | 1 | Invalidate strobe |
| inv_op | input | EA_W | Invalidate operand |

## Verification
A wrong valid bit, a wrong tag or a wrong victim pointer stays hidden until a later lookup of the affected page. That lookup then shows a spurious miss or a stale real address one cycle after it is accepted. The bench therefore follows every fill and invalidate with lookups of both the touched page and its set neighbours. A wrong fault flag shows at once, in the very next cycle, as a wrong `req_ready`, because the cancel rule depends on that flag.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
  // Page attributes stored per entry; bit 0 is priv_only, bit 5 is inhibit.
  typedef struct packed {
    logic inhibit;
    logic chg;
    logic refd;
    logic wr_ok;
    logic rd_ok;
    logic priv_only;
  } pte_attr_t;
endpackage

// File: rtl/dtlb_way.sv
module dtlb_way #(
  parameter int SETS  = 64,
  parameter int TAG_W = 46,
  parameter int RPN_W = 44
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(SETS)-1:0]  rd_set,
  input  logic [TAG_W-1:0]         rd_tag,
  output logic                     rd_hit,
  output logic [RPN_W-1:0]         rd_rpn,
  output dtlb_pkg::pte_attr_t      rd_attr,
  input  logic [TAG_W-1:0]         pr_tag,
  output logic                     pr_hit,
  input  logic                     wr_en,
  input  logic [$clog2(SETS)-1:0]  wr_set,
  input  logic [RPN_W-1:0]         wr_rpn,
  input  dtlb_pkg::pte_attr_t      wr_attr,
  input  logic                     clr_all,
  input  logic                     clr_one,
  input  logic [$clog2(SETS)-1:0]  clr_set,
  input  logic [TAG_W-1:0]         clr_tag
);
  logic [SETS-1:0]      vld;
  logic [TAG_W-1:0]     tag_q  [SETS];
  logic [RPN_W-1:0]     rpn_q  [SETS];
  dtlb_pkg::pte_attr_t  attr_q [SETS];

  always_comb begin
    rd_hit  = vld[rd_set] && (tag_q[rd_set] == rd_tag);
    rd_rpn  = rpn_q[rd_set];
    rd_attr = attr_q[rd_set];
    pr_hit  = vld[wr_set] && (tag_q[wr_set] == pr_tag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
    end else if (clr_all) begin
      vld <= '0;
    end else begin
      if (clr_one && vld[clr_set] && (tag_q[clr_set] == clr_tag))
        vld[clr_set] <= 1'b0;
      if (wr_en)
        vld[wr_set] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set]  <= pr_tag;
      rpn_q[wr_set]  <= wr_rpn;
      attr_q[wr_set] <= wr_attr;
    end
  end
endmodule

// File: rtl/dtlb_victim.sv
module dtlb_victim #(
  parameter int SETS = 64,
  parameter int WAYS = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(SETS)-1:0]  sel_set,
  input  logic                     advance,
  output logic [WAY_W-1:0]         victim
);
  logic [WAY_W-1:0] ptr [SETS];

  assign victim = ptr[sel_set];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) ptr[s] <= '0;
    end else if (advance) begin
      if (ptr[sel_set] == WAY_W'(WAYS - 1)) ptr[sel_set] <= '0;
      else ptr[sel_set] <= ptr[sel_set] + 1'b1;
    end
  end
endmodule

// File: rtl/dtlb_access_check.sv
module dtlb_access_check (
  input  dtlb_pkg::pte_attr_t attr,
  input  logic                is_store,
  input  logic                problem,
  output logic                perm_err,
  output logic                rc_err
);
  always_comb begin
    perm_err = (attr.priv_only && problem) ||
               (is_store ? !attr.wr_ok : !(attr.rd_ok || attr.wr_ok));
    rc_err   = !attr.refd || (is_store && !attr.chg);
  end
endmodule

// File: rtl/dtlb_core.sv
module dtlb_core #(
  parameter int EA_W       = 64,
  parameter int RA_W       = 56,
  parameter int SETS       = 64,
  parameter int WAYS       = 2,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       relocate,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [EA_W-1:0]            req_ea,
  input  logic                       req_store,
  input  logic                       req_problem,
  output logic                       rsp_valid,
  output logic [RA_W-1:0]            rsp_ra,
  output logic                       rsp_inhibit,
  output logic                       rsp_hit,
  output logic                       rsp_miss,
  output logic                       rsp_perm_err,
  output logic                       rsp_rc_err,
  input  logic                       fill_valid,
  input  logic [EA_W-PAGE_SHIFT-1:0] fill_page,
  input  logic [RA_W-PAGE_SHIFT-1:0] fill_rpn,
  input  logic [5:0]                 fill_attr,
  input  logic                       inv_valid,
  input  logic [EA_W-1:0]            inv_op
);
  import dtlb_pkg::*;

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = EA_W - PAGE_SHIFT - IDX_W;
  localparam int RPN_W = RA_W - PAGE_SHIFT;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic unused_ok;
  assign unused_ok = ^inv_op[9:0];

  logic [IDX_W-1:0] req_set, fill_set, inv_set;
  logic [TAG_W-1:0] req_tag, fill_tag, inv_tag;
  assign req_set  = req_ea[PAGE_SHIFT +: IDX_W];
  assign req_tag  = req_ea[EA_W-1 -: TAG_W];
  assign fill_set = fill_page[IDX_W-1:0];
  assign fill_tag = fill_page[EA_W-PAGE_SHIFT-1 -: TAG_W];
  assign inv_set  = inv_op[PAGE_SHIFT +: IDX_W];
  assign inv_tag  = inv_op[EA_W-1 -: TAG_W];

  logic flush_all, drop_one, fill_do;
  assign flush_all = inv_valid && (inv_op[10] || inv_op[11]);
  assign drop_one  = inv_valid && !flush_all;
  assign fill_do   = fill_valid && !inv_valid;

  logic [WAYS-1:0]  way_hit, way_fhit, way_wr;
  logic [RPN_W-1:0] way_rpn  [WAYS];
  pte_attr_t        way_attr [WAYS];
  logic [WAY_W-1:0] victim, fill_way, fhit_way;
  logic             any_hit, any_fhit;
  logic [RPN_W-1:0] hit_rpn;
  pte_attr_t        hit_attr;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_wr[w] = fill_do && (fill_way == WAY_W'(w));
    dtlb_way #(.SETS(SETS), .TAG_W(TAG_W), .RPN_W(RPN_W)) way_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_set  (req_set),
      .rd_tag  (req_tag),
      .rd_hit  (way_hit[w]),
      .rd_rpn  (way_rpn[w]),
      .rd_attr (way_attr[w]),
      .pr_tag  (fill_tag),
      .pr_hit  (way_fhit[w]),
      .wr_en   (way_wr[w]),
      .wr_set  (fill_set),
      .wr_rpn  (fill_rpn),
      .wr_attr (pte_attr_t'(fill_attr)),
      .clr_all (flush_all),
      .clr_one (drop_one),
      .clr_set (inv_set),
      .clr_tag (inv_tag)
    );
  end

  always_comb begin
    any_hit  = 1'b0;
    hit_rpn  = '0;
    hit_attr = '0;
    any_fhit = 1'b0;
    fhit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) begin
        any_hit  = 1'b1;
        hit_rpn  = way_rpn[w];
        hit_attr = way_attr[w];
      end
      if (way_fhit[w]) begin
        any_fhit = 1'b1;
        fhit_way = WAY_W'(w);
      end
    end
  end

  assign fill_way = any_fhit ? fhit_way : victim;

  dtlb_victim #(.SETS(SETS), .WAYS(WAYS)) victim_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_set (fill_set),
    .advance (fill_do && !any_fhit),
    .victim  (victim)
  );

  logic chk_perm, chk_rc;
  dtlb_access_check check_i (
    .attr     (hit_attr),
    .is_store (req_store),
    .problem  (req_problem),
    .perm_err (chk_perm),
    .rc_err   (chk_rc)
  );

  logic [RA_W-1:0] nx_ra;
  logic nx_ci, nx_hit, nx_miss, nx_perm, nx_rc;
  always_comb begin
    nx_ra   = '0;
    nx_ci   = 1'b0;
    nx_hit  = 1'b0;
    nx_miss = 1'b0;
    nx_perm = 1'b0;
    nx_rc   = 1'b0;
    if (!relocate) begin
      nx_hit = 1'b1;
      nx_ra  = req_ea[RA_W-1:0];
      nx_ci  = (req_ea[31:28] == 4'hC);
    end else if (!any_hit) begin
      nx_miss = 1'b1;
    end else begin
      nx_ra   = {hit_rpn, req_ea[PAGE_SHIFT-1:0]};
      nx_ci   = hit_attr.inhibit;
      nx_perm = chk_perm;
      nx_rc   = chk_rc;
      nx_hit  = !chk_perm && !chk_rc;
    end
  end

  logic accept;
  assign accept    = req_valid && req_ready;
  assign req_ready = !(rsp_valid && !rsp_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_ra       <= '0;
      rsp_inhibit  <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_miss     <= 1'b0;
      rsp_perm_err <= 1'b0;
      rsp_rc_err   <= 1'b0;
    end else begin
      rsp_valid    <= accept;
      rsp_hit      <= accept && nx_hit;
      rsp_miss     <= accept && nx_miss;
      rsp_perm_err <= accept && nx_perm;
      rsp_rc_err   <= accept && nx_rc;
      if (accept) begin
        rsp_ra      <= nx_ra;
        rsp_inhibit <= nx_ci;
      end
    end
  end
endmodule

// File: rtl/dtlb_core_chk.sv
module dtlb_core_chk #(
  parameter int EA_W = 64,
  parameter int RA_W = 56
) (
  input logic            clk,
  input logic            rst_n,
  input logic            relocate,
  input logic            req_valid,
  input logic            req_ready,
  input logic [EA_W-1:0] req_ea,
  input logic            rsp_valid,
  input logic [RA_W-1:0] rsp_ra,
  input logic            rsp_inhibit,
  input logic            rsp_hit,
  input logic            rsp_miss,
  input logic            rsp_perm_err,
  input logic            rsp_rc_err,
  input logic            inv_valid,
  input logic [EA_W-1:0] inv_op
);
  logic            accept, ci_win, flush_now;
  logic [RA_W-1:0] ea_lo;
  assign accept    = req_valid && req_ready;
  assign ea_lo     = req_ea[RA_W-1:0];
  assign ci_win    = (req_ea[31:28] == 4'hC);
  assign flush_now = inv_valid && (inv_op[10] || inv_op[11]);

  a_r1_one_cycle_resp: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  a_r1_outcome_excl: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit != (rsp_miss || rsp_perm_err || rsp_rc_err)));

  a_r4_miss_alone: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (!rsp_perm_err && !rsp_rc_err && !rsp_hit));

  a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !relocate) |=> (rsp_hit && rsp_ra == $past(ea_lo)));

  a_r3_window_ci: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !relocate) |=> (rsp_inhibit == $past(ci_win)));

  a_r8_cancel_next: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |=> !rsp_valid);

  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && relocate && $past(flush_now)) |=> rsp_miss);
endmodule

bind dtlb_core dtlb_core_chk #(.EA_W(EA_W), .RA_W(RA_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .relocate     (relocate),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_ea       (req_ea),
  .rsp_valid    (rsp_valid),
  .rsp_ra       (rsp_ra),
  .rsp_inhibit  (rsp_inhibit),
  .rsp_hit      (rsp_hit),
  .rsp_miss     (rsp_miss),
  .rsp_perm_err (rsp_perm_err),
  .rsp_rc_err   (rsp_rc_err),
  .inv_valid    (inv_valid),
  .inv_op       (inv_op)
);

// File: tb/dtlb_core_tb_top.sv
`timescale 1ns/1ps
module dtlb_core_tb_top;
  localparam int EA_W = 64, RA_W = 56, RPN_W = 44, PG_W = 52;
  localparam logic [5:0] FULL = 6'b011110;

  logic clk = 1'b0, rst_n = 1'b0;
  logic relocate = 0, req_valid = 0, req_store = 0, req_problem = 0;
  logic [EA_W-1:0] req_ea = '0, inv_op = '0;
  logic req_ready, rsp_valid, rsp_inhibit, rsp_hit, rsp_miss, rsp_perm_err, rsp_rc_err;
  logic [RA_W-1:0] rsp_ra;
  logic fill_valid = 0, inv_valid = 0;
  logic [PG_W-1:0] fill_page = '0;
  logic [RPN_W-1:0] fill_rpn = '0;
  logic [5:0] fill_attr = '0;

  always #2.5 clk = ~clk;

  dtlb_core dut_i (.*);

  bit              mv   [64][2];
  logic [PG_W-1:0] mpg  [64][2];
  logic [RPN_W-1:0] mrpn[64][2];
  logic [5:0]      mat  [64][2];
  bit              mvic [64];
  int checks = 0, fails = 0;
  bit last_err = 0, done = 0;

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_ea(int tagk, int set, int off);
    return {46'(tagk), 6'(set), 12'(off)};
  endfunction

  task automatic lookup(string rq, logic [63:0] ea, bit st, bit pr, bit rel);
    bit h, m, p, r, ci; logic [RA_W-1:0] ra; int s, hw;
    h = 0; m = 0; p = 0; r = 0; ci = 0; ra = '0;
    if (!rel) begin
      h = 1; ra = ea[RA_W-1:0]; ci = (ea[31:28] == 4'hC);
    end else begin
      s = int'(ea[17:12]); hw = -1;
      for (int w = 0; w < 2; w++) if (mv[s][w] && mpg[s][w] == ea[63:12]) hw = w;
      if (hw < 0) m = 1;
      else begin
        logic [5:0] a; a = mat[s][hw];
        p = (a[0] && pr) || (st ? !a[2] : !(a[1] || a[2]));
        r = !a[3] || (st && !a[4]);
        h = !p && !r; ra = {mrpn[s][hw], ea[11:0]}; ci = a[5];
      end
    end
    req_valid = 1; req_ea = ea; req_store = st; req_problem = pr; relocate = rel;
    chk({rq, " R8 ready"}, 64'(req_ready), 64'(!last_err));
    @(negedge clk);
    req_valid = 0;
    if (last_err) begin
      chk({rq, " R8 cancelled"}, 64'(rsp_valid), 64'd0);
      last_err = 0;
    end else begin
      chk({rq, " R1 valid"}, 64'(rsp_valid), 64'd1);
      chk({rq, " flags"}, 64'({rsp_hit, rsp_miss, rsp_perm_err, rsp_rc_err}), 64'({h, m, p, r}));
      if (h) begin
        chk({rq, " ra"}, 64'(rsp_ra), 64'(ra));
        chk({rq, " ci"}, 64'(rsp_inhibit), 64'(ci));
      end
      last_err = !h;
    end
  endtask

  task automatic maint(bit fv, logic [63:0] fea, logic [RPN_W-1:0] frpn, logic [5:0] fat,
                       bit iv, logic [63:0] iop);
    int s, hw;
    fill_valid = fv; fill_page = fea[63:12]; fill_rpn = frpn; fill_attr = fat;
    inv_valid = iv; inv_op = iop;
    @(negedge clk);
    fill_valid = 0; inv_valid = 0; last_err = 0;
    if (iv) begin
      for (int a = 0; a < 64; a++)
        for (int w = 0; w < 2; w++)
          if (iop[10] || iop[11] || (a == int'(iop[17:12]) && mpg[a][w] == iop[63:12]))
            mv[a][w] = 0;
    end else if (fv) begin
      s = int'(fea[17:12]); hw = -1;
      for (int w = 0; w < 2; w++) if (mv[s][w] && mpg[s][w] == fea[63:12]) hw = w;
      if (hw < 0) begin hw = int'(mvic[s]); mvic[s] = ~mvic[s]; end
      mv[s][hw] = 1; mpg[s][hw] = fea[63:12]; mrpn[s][hw] = frpn; mat[s][hw] = fat;
    end
  endtask

  task automatic fill(logic [63:0] ea, logic [RPN_W-1:0] rpn, logic [5:0] at);
    maint(1, ea, rpn, at, 0, '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset ready", 64'(req_ready), 64'd1);
    chk("R1 reset valid", 64'(rsp_valid), 64'd0);

    lookup("R2 R3 window", 64'h0000_0000_C000_1234, 0, 1, 0);
    lookup("R2 R3 outside", 64'h0000_0000_4000_5678, 1, 0, 0);
    lookup("R2 R3 high bits", 64'hFFFF_0000_C000_0010, 0, 0, 0);
    lookup("R4 empty miss", mk_ea(11, 1, 12'h100), 0, 0, 1);
    lookup("R8 after miss", mk_ea(11, 1, 12'h100), 0, 0, 0);

    fill(mk_ea(11, 1, 0), 44'h123_4567_89A, FULL);
    lookup("R5 load hit", mk_ea(11, 1, 12'hABC), 0, 1, 1);
    lookup("R5 store hit", mk_ea(11, 1, 12'h004), 1, 1, 1);
    fill(mk_ea(12, 2, 0), 44'h00F_0000_001, FULL | 6'b100001);
    lookup("R6 priv problem", mk_ea(12, 2, 12'h8), 0, 1, 1);
    lookup("R8 after perm", mk_ea(11, 1, 12'h8), 0, 0, 1);
    lookup("R5 R6 priv super ci", mk_ea(12, 2, 12'h8), 0, 0, 1);
    fill(mk_ea(13, 3, 0), 44'h3, 6'b011010);
    lookup("R6 store read-only", mk_ea(13, 3, 0), 1, 0, 1);
    maint(0, '0, '0, '0, 0, '0);
    lookup("R6 load read-only", mk_ea(13, 3, 0), 0, 0, 1);
    fill(mk_ea(14, 4, 0), 44'h4, 6'b011100);
    lookup("R6 load write-only", mk_ea(14, 4, 0), 0, 0, 1);
    fill(mk_ea(15, 5, 0), 44'h5, 6'b010110);
    lookup("R7 no ref", mk_ea(15, 5, 0), 0, 0, 1);
    fill(mk_ea(16, 6, 0), 44'h6, 6'b001110);
    lookup("R7 store no chg", mk_ea(16, 6, 0), 1, 0, 1);
    maint(0, '0, '0, '0, 0, '0);
    lookup("R7 load no chg", mk_ea(16, 6, 0), 0, 0, 1);
    fill(mk_ea(17, 7, 0), 44'h7, 6'b001010);
    lookup("R7 both faults", mk_ea(17, 7, 0), 1, 0, 1);

    fill(mk_ea(21, 20, 0), 44'h21, FULL);
    fill(mk_ea(22, 21, 0), 44'h22, FULL);
    fill(mk_ea(23, 20, 0), 44'h23, FULL);
    fill(mk_ea(24, 20, 0), 44'h24, FULL);
    lookup("R9 evicted", mk_ea(21, 20, 0), 0, 0, 1);
    maint(0, '0, '0, '0, 0, '0);
    lookup("R9 second", mk_ea(23, 20, 0), 0, 0, 1);
    lookup("R9 third", mk_ea(24, 20, 0), 0, 0, 1);
    lookup("R9 other set", mk_ea(22, 21, 0), 0, 0, 1);

    fill(mk_ea(31, 30, 0), 44'h31, FULL);
    fill(mk_ea(31, 30, 0), 44'hABC, FULL);
    fill(mk_ea(32, 30, 0), 44'h32, FULL);
    lookup("R10 replaced", mk_ea(31, 30, 0), 0, 0, 1);
    lookup("R10 neighbour", mk_ea(32, 30, 0), 0, 0, 1);

    maint(0, '0, '0, '0, 1, mk_ea(31, 30, 12'h3FF) & ~64'hC00);
    lookup("R12 dropped", mk_ea(31, 30, 0), 0, 0, 1);
    maint(0, '0, '0, '0, 0, '0);
    lookup("R12 kept", mk_ea(32, 30, 0), 0, 0, 1);

    maint(0, '0, '0, '0, 1, 64'h400);
    lookup("R11 bit10 flush", mk_ea(32, 30, 0), 0, 0, 1);
    fill(mk_ea(33, 33, 0), 44'h33, FULL);
    lookup("R11 refilled", mk_ea(33, 33, 0), 0, 0, 1);
    maint(0, '0, '0, '0, 1, 64'h800);
    lookup("R11 bit11 flush", mk_ea(33, 33, 0), 0, 0, 1);
    maint(1, mk_ea(34, 34, 0), 44'h34, FULL, 1, 64'h0);
    lookup("R13 fill dropped", mk_ea(34, 34, 0), 0, 0, 1);

    for (int n = 0; n < 1500; n++) begin
      int op; logic [63:0] ea;
      op = int'($urandom_range(0, 99));
      ea = mk_ea(int'($urandom_range(1, 4)), int'($urandom_range(40, 41)),
                 int'($urandom_range(0, 4095)));
      if (op < 55)
        lookup("R5 R6 R7 random", ea, 1'($urandom), 1'($urandom), 1);
      else if (op < 80)
        fill(ea, 44'({$urandom, $urandom}), 6'($urandom));
      else if (op < 88)
        maint(1'($urandom), ea, 44'($urandom), FULL, 1, ea & ~64'hC00);
      else if (op < 90)
        maint(0, '0, '0, '0, 1, 64'h800);
      else
        lookup("R2 R3 random", {$urandom, $urandom}, 1'($urandom), 1'($urandom), 0);
    end
    maint(0, '0, '0, '0, 0, '0);
    finish_run();
  end
endmodule